// File: doc/BRIEF.md
# Two-Pump Tank Fill Controller

This block runs the fill cycle of a water tank that has two pumps. Three level switches report whether the water stands at or above the low, middle and full marks. When the water falls below the low mark, the main pump starts. It keeps running until the full mark is covered.

A fill timer is cleared each time a fill starts. It counts clock cycles until the water first covers the middle mark. If the timer runs out before that, the auxiliary pump joins the main pump for the rest of the fill. Both pumps stop when the full mark is reached.

A combination of switches that cannot occur is treated as a sensor fault. During a fault both pumps are off and a fault flag is raised. Every switch input is synchronised to the clock before any logic uses it. The timeout is a cycle-count parameter, so a bench can shorten it.

Top module: `tank_fill_ctrl`

## Requirements
- R1: Each level input passes through two synchronising flops, so a change on a level pin first affects the outputs after the third rising clock edge following the change, and not before.
- R2: While the synchronous active-high reset is sampled high, both pump outputs are 0, the fault flag is 0, and the synchronisers are loaded as if all three marks were covered (tank full).
- R3: Level inputs are 1 when the water is at or above that mark. From idle, with consistent switches, a 0 on the low switch turns the main pump on and clears the fill timer.
- R4: The fill timer increments once per cycle while the main pump alone runs and the middle mark has not been seen. If it reaches TIMEOUT_CYC with the middle mark still unseen, the auxiliary pump turns on exactly TIMEOUT_CYC+1 cycles after the main pump turned on.
- R5: Once the synchronised middle switch reads 1 during a single-pump fill, the timer freezes and the auxiliary pump stays off for the rest of that fill. This includes the case where the middle mark arrives in the same cycle the timer expires: the middle mark wins.
- R6: A synchronised 1 on the full switch turns both pumps off, whether one or two pumps are running. The controller then stays idle until the low switch reads 0 again.
- R7: The switches are inconsistent when full=1 with middle=0, or middle=1 with low=0. In that case both pumps turn off and the fault flag is 1. The flag returns to 0 once the switches are consistent, and a fill may start from that same cycle.
- R8: Reset applied during a fill stops both pumps at the first reset edge. After release, no fill starts unless the low switch reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_low_i | input | 1 | 1 when water covers the low mark (asynchronous) |
| lvl_mid_i | input | 1 | 1 when water covers the middle mark (asynchronous) |
| lvl_high_i | input | 1 | 1 when water covers the full mark (asynchronous) |
| pump_main_o | output | 1 | Run command for the main pump |
| pump_aux_o | output | 1 | Run command for the auxiliary pump |
| sensor_fault_o | output | 1 | Inconsistent switch combination seen |

## Verification
Two events can fall in the same cycle: the fill timer reaching its limit, and the synchronised middle switch first reading 1. The bench times the middle-switch edge against a known start edge so that both land together. It expects the auxiliary pump to stay off. It then shifts the edge one cycle later and expects the auxiliary pump to start on that cycle. Around this race, the bench also checks the exact cycle of escalation, the hysteresis after a full stop, faults raised from idle and during a fill, and reset during a two-pump fill.

// File: rtl/tank_pkg.sv
package tank_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SOLO = 2'd1,
    ST_DUAL = 2'd2
  } fill_st_e;

  typedef struct packed {
    logic high;
    logic mid;
    logic low;
  } lvl_t;

  localparam int unsigned LVL_W = $bits(lvl_t);

endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end

endmodule

// File: rtl/fill_timer.sv
module fill_timer #(
  parameter longint unsigned LIMIT = 64'd15_000_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt <= '0;
    else if (en_i && cnt != LIM_V) cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LIM_V);

  // R4: the count never passes the limit
  a_r4_cnt_sat: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM_V);

  // R5: the count holds while counting is not enabled
  a_r5_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(cnt));

endmodule

// File: rtl/fill_fsm.sv
module fill_fsm
  import tank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  lvl_t lvl_i,
  input  logic tmr_done_i,
  output logic tmr_clr_o,
  output logic tmr_en_o,
  output logic main_o,
  output logic aux_o,
  output logic fault_o
);

  fill_st_e st, nxt;
  logic     mid_seen_q;
  logic     fault_q;
  logic     bad;
  logic     mid_ok;

  assign bad    = (lvl_i.high & ~lvl_i.mid) | (lvl_i.mid & ~lvl_i.low);
  assign mid_ok = mid_seen_q | lvl_i.mid;

  always_comb begin
    nxt = st;
    if (bad) begin
      nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (!lvl_i.low) nxt = ST_SOLO;
        ST_SOLO: begin
          if (lvl_i.high)                nxt = ST_IDLE;
          else if (tmr_done_i && !mid_ok) nxt = ST_DUAL;
        end
        ST_DUAL: if (lvl_i.high) nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mid_seen_q <= 1'b0;
      fault_q    <= 1'b0;
    end else begin
      st         <= nxt;
      fault_q    <= bad;
      if (st != ST_SOLO)   mid_seen_q <= 1'b0;
      else if (lvl_i.mid)  mid_seen_q <= 1'b1;
    end
  end

  assign tmr_clr_o = (st == ST_IDLE);
  assign tmr_en_o  = (st == ST_SOLO) && !mid_ok;
  assign main_o    = (st != ST_IDLE);
  assign aux_o     = (st == ST_DUAL);
  assign fault_o   = fault_q;

  // R6: a covered full mark ends any fill on the next edge
  a_r6_full_stops: assert property (@(posedge clk) disable iff (rst)
    (lvl_i.high && !bad && st != ST_IDLE) |=> st == ST_IDLE);

  // R5: middle mark seen during single-pump fill blocks escalation
  a_r5_mid_blocks: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SOLO && mid_ok) |=> st != ST_DUAL);

  // R4: no escalation before the timer has expired
  a_r4_no_early: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SOLO && !tmr_done_i) |=> st != ST_DUAL);

  // R7: inconsistent switches force idle and raise the flag
  a_r7_fault_idle: assert property (@(posedge clk) disable iff (rst)
    bad |=> (st == ST_IDLE && fault_q));

  // R3: start only from idle with the low mark uncovered
  a_r3_start_cond: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && (lvl_i.low || bad)) |=> st == ST_IDLE);

endmodule

// File: rtl/tank_fill_ctrl.sv
module tank_fill_ctrl
  import tank_pkg::*;
#(
  parameter longint unsigned TIMEOUT_CYC = 64'd15_000_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_low_i,
  input  logic lvl_mid_i,
  input  logic lvl_high_i,
  output logic pump_main_o,
  output logic pump_aux_o,
  output logic sensor_fault_o
);

  lvl_t raw_lvl, sync_lvl;
  logic tmr_clr, tmr_en, tmr_done;

  assign raw_lvl = '{high: lvl_high_i, mid: lvl_mid_i, low: lvl_low_i};

  level_sync #(
    .W      (LVL_W),
    .RST_VAL({LVL_W{1'b1}})
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(raw_lvl),
    .q_o(sync_lvl)
  );

  fill_timer #(
    .LIMIT(TIMEOUT_CYC)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .done_o(tmr_done)
  );

  fill_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .lvl_i     (sync_lvl),
    .tmr_done_i(tmr_done),
    .tmr_clr_o (tmr_clr),
    .tmr_en_o  (tmr_en),
    .main_o    (pump_main_o),
    .aux_o     (pump_aux_o),
    .fault_o   (sensor_fault_o)
  );

  // R2: nothing runs and no fault is reported in the cycle after reset
  a_r2_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pump_main_o && !pump_aux_o && !sensor_fault_o));

  // R6: the auxiliary pump never runs without the main pump
  a_r6_aux_needs_main: assert property (@(posedge clk) disable iff (rst)
    pump_aux_o |-> pump_main_o);

endmodule

// File: tb/test_tank_fill_ctrl.sv
module test_tank_fill_ctrl;

  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lo = 1'b1, md = 1'b1, hi = 1'b1;
  logic p_main, p_aux, flt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tank_fill_ctrl #(.TIMEOUT_CYC(TMO)) i_tank_fill_ctrl (
    .clk(clk), .rst(rst),
    .lvl_low_i(lo), .lvl_mid_i(md), .lvl_high_i(hi),
    .pump_main_o(p_main), .pump_aux_o(p_aux), .sensor_fault_o(flt)
  );

  // {low, mid, high, exp_main, exp_aux, exp_fault}
  localparam int NV = 16;
  localparam logic [5:0] VEC [NV] = '{
    6'b111_000,  // idle, tank full
    6'b110_000,  // below full: still idle (R6 hysteresis)
    6'b100_000,  // below middle: still idle
    6'b000_100,  // below low: main starts (R3)
    6'b100_100,  // rising
    6'b110_100,  // middle covered early (R5)
    6'b110_100,
    6'b110_100,
    6'b110_100,
    6'b110_100,  // timer limit passed, aux still off (R5)
    6'b111_000,  // full: stop (R6)
    6'b001_001,  // full without others: fault (R7)
    6'b111_000,  // fault clears
    6'b010_001,  // middle without low: fault (R7)
    6'b000_100,  // fault clears and fill starts together (R7)
    6'b101_001   // fault during fill stops main (R7)
  };

  task automatic check(string req, logic a, logic b, logic f);
    checks++;
    if (p_main !== a || p_aux !== b || flt !== f) begin
      errors++;
      $display("FAIL %s: got main=%b aux=%b fault=%b expected main=%b aux=%b fault=%b",
               req, p_main, p_aux, flt, a, b, f);
    end
  endtask

  task automatic drive(logic l, logic m, logic h);
    lo = l; md = m; hi = h;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset", 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R2 reset holds synchronisers full", 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1);
    rst = 1'b0;
    settle();

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3]);
      settle();
      check($sformatf("R3/R5/R6/R7 vector %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R1 latency and R4 exact escalation
    drive(1'b1, 1'b1, 1'b1);
    settle();
    drive(1'b0, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 no effect after two edges", 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R1 main after third edge", 1'b1, 1'b0, 1'b0);
    repeat (TMO) @(posedge clk);
    @(negedge clk);
    check("R4 aux off at limit", 1'b1, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R4 aux on one cycle after limit", 1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    settle();
    check("R4 aux stays on after middle", 1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b1);
    settle();
    check("R6 full stops both pumps", 1'b0, 1'b0, 1'b0);

    // R5 race: middle arrives in the expiry cycle
    drive(1'b0, 1'b0, 1'b0);
    settle();
    check("R3 restart", 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    repeat (TMO - 2) @(posedge clk);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 middle wins same-cycle expiry", 1'b1, 1'b0, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R5 aux stays off", 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1);
    settle();
    check("R6 stop", 1'b0, 1'b0, 1'b0);

    // R5 boundary: middle one cycle late escalates
    drive(1'b0, 1'b0, 1'b0);
    settle();
    drive(1'b1, 1'b0, 1'b0);
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 middle one cycle late", 1'b1, 1'b1, 1'b0);

    // R8 reset during two-pump fill
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 reset stops pumps", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 no restart with low covered", 1'b0, 1'b0, 1'b0);

    finish_run();
  end

endmodule